// File: doc/BRIEF.md
# Open-Row Banked Byte Memory

This block is a banked memory with a byte-wide host port. Each bank keeps exactly one row open in a row buffer. Reads and writes that fall in the open row are served from that buffer at one byte per cycle, so the buffer works as a small cache in front of the bank's storage array. A request to any other row of a bank is not served. The block answers it with a miss flag on the cycle after the request and starts opening the new row. The bank then stays busy for a programmable load latency. During that window the host may work with every other bank, and it must reissue the missed request once the bank is ready again.

Banks that are neither loading nor serving the host sit in standby. A one-register configuration space shares the request port. It selects whether reads, writes or both are allowed. Modified row contents are written back to the array when the bank opens a different row.

Top module: `open_row_mem`

## Requirements
- R1: The number of banks (1, 2 or 4), rows per bank, columns per row and data width (8, or 9 with the spare bit) are parameters. A row holds columns × data width bits, 2048 by default. Column 0 and the last column are both addressable.
- R2: A read (`req_we`=0) to the open row of a ready bank raises `rsp_valid` with that column's byte on `rsp_rdata` one cycle later. Back-to-back hits each return their byte with no gap cycle.
- R3: A write (`req_we`=1) to the open row of a ready bank updates the row buffer at once, so a read on the very next cycle returns the new byte. A write raises no response flag.
- R4: A request to a bank that has no open row, or that has a different row open, raises `rsp_miss` one cycle later. The request is dropped: it returns no data, and a write does not change any stored byte.
- R5: After a miss, the addressed bank's `bank_busy` is high for exactly LOAD_LAT cycles, starting on the cycle after the miss. LOAD_LAT defaults to 8.
- R6: A data request to a busy bank raises `rsp_retry` one cycle later and has no other effect.
- R7: While one bank is busy, data requests to other banks are served, or reported as misses, exactly as they would be if that bank were idle.
- R8: `bank_standby` of a bank is high unless that bank is busy, or it accepted a hit on the previous cycle. After reset every bank is in standby, is not busy, and has no open row, so the first access to each bank misses.
- R9: Bytes written to a row survive closing that row and opening it again, because the row buffer is written back when another row is opened.
- R10: A request with `req_cfg`=1 writes the mode register from `req_wdata[1:0]`, returns no response flag and touches no bank. Bit 0 set blocks reads: a hit returns no `rsp_valid`. Bit 1 set blocks writes: a hit leaves the byte unchanged. The register resets to 0.
- R11: At most one of `rsp_valid`, `rsp_miss` and `rsp_retry` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_cfg | input | 1 | Request is a mode-register write |
| req_bank | input | BANK_W | Bank address |
| req_row | input | ROW_W | Row address within the bank |
| req_col | input | COL_W | Column (byte) address within the row |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data, or the mode value for a configuration write |
| rsp_valid | output | 1 | Read data valid, one cycle after a read hit |
| rsp_rdata | output | DW | Read data |
| rsp_miss | output | 1 | Previous request missed the open row and was dropped |
| rsp_retry | output | 1 | Previous request hit a busy bank and was refused |
| bank_busy | output | NUM_BANKS | Per-bank row-load in progress |
| bank_standby | output | NUM_BANKS | Per-bank standby state |

## Verification
The checker watches, on every cycle, that the three response flags exclude each other, and that each internal hit, miss or retry event turns into the matching flag one cycle later. It also checks that a missing bank goes busy and a bank that served a hit leaves standby, and that a read response never appears while reads are blocked. Only the bench scenarios can show the data behaviour: the exact byte returned, writes seen on the next cycle, write-back across a row change, and dropped writes. The same holds for the exact length of the busy window, service to other banks during a load, and the effect of each mode setting.

// File: rtl/orm_pkg.sv
package orm_pkg;

  // Access mode register: bit 0 blocks reads, bit 1 blocks writes.
  typedef struct packed {
    logic wr_off;
    logic rd_off;
  } mode_t;

  function automatic mode_t decode_mode(input logic [1:0] raw);
    mode_t m;
    m.rd_off = raw[0];
    m.wr_off = raw[1];
    return m;
  endfunction

  function automatic int unsigned row_bits(input int unsigned cols, input int unsigned dw);
    return cols * dw;
  endfunction

endpackage

// File: rtl/orm_bank.sv
module orm_bank #(
  parameter int ROWS     = 4,
  parameter int COLS     = 256,
  parameter int DW       = 8,
  parameter int LOAD_LAT = 8,
  localparam int ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W   = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  output logic             hit_ev,
  output logic             miss_ev,
  output logic             retry_ev,
  output logic             busy,
  output logic             standby,
  output logic [DW-1:0]    rd_byte
);
  import orm_pkg::*;

  localparam int RB    = row_bits(COLS, DW);
  localparam int CNT_W = $clog2(LOAD_LAT + 1);

  logic [RB-1:0]    rowbuf;
  logic [RB-1:0]    arr [ROWS];
  logic             open_v;
  logic [ROW_W-1:0] open_row;
  logic [CNT_W-1:0] cnt;
  logic             active_q;

  function automatic logic is_open(input logic v, input logic [ROW_W-1:0] cur,
                                   input logic [ROW_W-1:0] want);
    return v && (cur == want);
  endfunction

  assign busy     = (cnt != '0);
  assign retry_ev = sel && busy;
  assign hit_ev   = sel && !busy && is_open(open_v, open_row, row);
  assign miss_ev  = sel && !busy && !is_open(open_v, open_row, row);
  assign standby  = !busy && !active_q;
  assign rd_byte  = rowbuf[int'(col)*DW +: DW];

  // Storage array and row buffer: data only, no reset.
  always_ff @(posedge clk) begin
    if (miss_ev) begin
      if (open_v) arr[open_row] <= rowbuf;
      rowbuf <= arr[row];
    end else if (hit_ev && wr_en) begin
      rowbuf[int'(col)*DW +: DW] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_v   <= 1'b0;
      open_row <= '0;
      cnt      <= '0;
      active_q <= 1'b0;
    end else begin
      active_q <= hit_ev;
      if (miss_ev) begin
        open_v   <= 1'b1;
        open_row <= row;
        cnt      <= CNT_W'(LOAD_LAT);
      end else if (busy) begin
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/orm_resp.sv
module orm_resp #(
  parameter int NB = 4,
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NB-1:0]        hit_ev,
  input  logic [NB-1:0]        miss_ev,
  input  logic [NB-1:0]        retry_ev,
  input  logic [NB-1:0][DW-1:0] rd_bytes,
  input  logic                 is_read,
  input  logic                 rd_off,
  output logic                 rsp_valid,
  output logic [DW-1:0]        rsp_rdata,
  output logic                 rsp_miss,
  output logic                 rsp_retry
);
  logic [DW-1:0] pick;

  // At most one bank is selected, so the hit vector is one-hot or zero.
  always_comb begin
    pick = '0;
    for (int b = 0; b < NB; b++) begin
      if (hit_ev[b]) pick = rd_bytes[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_miss  <= 1'b0;
      rsp_retry <= 1'b0;
    end else begin
      rsp_valid <= (|hit_ev) && is_read && !rd_off;
      rsp_miss  <= |miss_ev;
      rsp_retry <= |retry_ev;
      if ((|hit_ev) && is_read) rsp_rdata <= pick;
    end
  end

endmodule

// File: rtl/open_row_mem.sv
module open_row_mem #(
  parameter int NUM_BANKS = 4,
  parameter int ROWS      = 4,
  parameter int COLS      = 256,
  parameter int DW        = 8,
  parameter int LOAD_LAT  = 8,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W    = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_cfg,
  input  logic [BANK_W-1:0]    req_bank,
  input  logic [ROW_W-1:0]     req_row,
  input  logic [COL_W-1:0]     req_col,
  input  logic                 req_we,
  input  logic [DW-1:0]        req_wdata,
  output logic                 rsp_valid,
  output logic [DW-1:0]        rsp_rdata,
  output logic                 rsp_miss,
  output logic                 rsp_retry,
  output logic [NUM_BANKS-1:0] bank_busy,
  output logic [NUM_BANKS-1:0] bank_standby
);
  import orm_pkg::*;

  mode_t                        mode_q;
  logic [NUM_BANKS-1:0]         sel;
  logic [NUM_BANKS-1:0]         hit_ev;
  logic [NUM_BANKS-1:0]         miss_ev;
  logic [NUM_BANKS-1:0]         retry_ev;
  logic [NUM_BANKS-1:0][DW-1:0] rd_bytes;
  logic                         cfg_wr;
  logic                         wr_en;

  assign cfg_wr = req_valid && req_cfg;
  assign wr_en  = req_we && !mode_q.wr_off;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= '0;
    else if (cfg_wr) mode_q <= decode_mode(req_wdata[1:0]);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign sel[b] = req_valid && !req_cfg && (req_bank == BANK_W'(b));
    orm_bank #(
      .ROWS(ROWS), .COLS(COLS), .DW(DW), .LOAD_LAT(LOAD_LAT)
    ) i_bank (
      .clk(clk), .rst_n(rst_n), .sel(sel[b]),
      .row(req_row), .col(req_col), .wr_en(wr_en), .wdata(req_wdata),
      .hit_ev(hit_ev[b]), .miss_ev(miss_ev[b]), .retry_ev(retry_ev[b]),
      .busy(bank_busy[b]), .standby(bank_standby[b]), .rd_byte(rd_bytes[b])
    );
  end

  orm_resp #(.NB(NUM_BANKS), .DW(DW)) i_resp (
    .clk(clk), .rst_n(rst_n),
    .hit_ev(hit_ev), .miss_ev(miss_ev), .retry_ev(retry_ev),
    .rd_bytes(rd_bytes), .is_read(!req_we), .rd_off(mode_q.rd_off),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_miss(rsp_miss), .rsp_retry(rsp_retry)
  );

endmodule

// File: rtl/orm_chk.sv
module orm_chk #(
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_we,
  input logic [NB-1:0] hit_ev,
  input logic [NB-1:0] miss_ev,
  input logic [NB-1:0] retry_ev,
  input logic [NB-1:0] bank_busy,
  input logic [NB-1:0] bank_standby,
  input logic [1:0]    mode_q,
  input logic          rsp_valid,
  input logic          rsp_miss,
  input logic          rsp_retry
);

  p_one_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_valid, rsp_miss, rsp_retry}));

  p_hit_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hit_ev) && req_valid && !req_we && !mode_q[0]) |=> rsp_valid);

  p_miss_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|miss_ev) |=> rsp_miss);

  p_miss_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|miss_ev) |=> ((bank_busy & $past(miss_ev)) == $past(miss_ev)));

  p_retry_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|retry_ev) |=> rsp_retry);

  p_awake_after_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_ev) |=> ((bank_standby & $past(hit_ev)) == '0));

  p_read_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !$past(mode_q[0]));

endmodule

bind open_row_mem orm_chk #(.NB(NUM_BANKS)) i_orm_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
  .hit_ev(hit_ev), .miss_ev(miss_ev), .retry_ev(retry_ev),
  .bank_busy(bank_busy), .bank_standby(bank_standby), .mode_q(mode_q),
  .rsp_valid(rsp_valid), .rsp_miss(rsp_miss), .rsp_retry(rsp_retry)
);

// File: tb/test_open_row_mem.sv
module test_open_row_mem;
  localparam int NB  = 4;
  localparam int LAT = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_cfg, req_we;
  logic [1:0] req_bank, req_row;
  logic [7:0] req_col, req_wdata;
  logic       rsp_valid, rsp_miss, rsp_retry;
  logic [7:0] rsp_rdata;
  logic [NB-1:0] bank_busy, bank_standby;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  logic       c_valid, c_miss, c_retry;
  logic [7:0] c_data;

  always #4 clk = ~clk;

  open_row_mem #(.NUM_BANKS(NB), .ROWS(4), .COLS(256), .DW(8), .LOAD_LAT(LAT))
  i_open_row_mem (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cfg(req_cfg),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_we(req_we),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_miss(rsp_miss), .rsp_retry(rsp_retry), .bank_busy(bank_busy),
    .bank_standby(bank_standby)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; drives one request, captures the response at
  // the next falling edge and leaves the port idle.
  task automatic req(input logic cfg, input int bank, input int row, input int col,
                     input logic we, input logic [7:0] wd);
    req_valid = 1'b1; req_cfg = cfg; req_bank = 2'(bank); req_row = 2'(row);
    req_col = 8'(col); req_we = we; req_wdata = wd;
    @(negedge clk);
    c_valid = rsp_valid; c_miss = rsp_miss; c_retry = rsp_retry; c_data = rsp_rdata;
    req_valid = 1'b0; req_cfg = 1'b0; req_we = 1'b0;
  endtask

  task automatic flags(input string tag, input logic v, input logic m, input logic r);
    check({tag, " flags"}, {29'd0, c_valid, c_miss, c_retry}, {29'd0, v, m, r});
  endtask

  task automatic wait_ready();
    while (bank_busy != '0) @(negedge clk);
  endtask

  task automatic open_row(input int bank, input int row);
    req(0, bank, row, 0, 0, 8'h00);
    wait_ready();
  endtask

  task automatic t_reset();
    check("R8 reset standby", 32'(bank_standby), 32'hF);
    check("R8 reset busy", 32'(bank_busy), 32'h0);
    check("R11 reset flags", {29'd0, rsp_valid, rsp_miss, rsp_retry}, 32'd0);
  endtask

  task automatic t_miss_busy();
    int n;
    req(0, 0, 1, 5, 0, 8'h00);
    flags("R4 first access misses R8", 0, 1, 0);
    n = 0;
    while (bank_busy[0]) begin n++; @(negedge clk); end
    check("R5 busy length", 32'(n), 32'(LAT));
    req(0, 1, 0, 0, 0, 8'h00);
    flags("R4 miss bank1", 0, 1, 0);
    req(0, 1, 0, 0, 0, 8'h00);
    flags("R6 retry on busy bank", 0, 0, 1);
    req(0, 2, 0, 0, 0, 8'h00);
    flags("R7 other bank accepted while busy", 0, 1, 0);
    check("R7 bank1 still busy", 32'(bank_busy[1]), 32'd1);
    wait_ready();
  endtask

  task automatic t_stream();
    for (int i = 0; i < 8; i++) begin
      req(0, 0, 1, i, 1, 8'h30 + 8'(i));
      flags("R3 write no flag", 0, 0, 0);
    end
    req(0, 0, 1, 255, 1, 8'hC3);
    req(0, 0, 1, 255, 0, 8'h00);
    flags("R1 last column", 1, 0, 0);
    check("R1 last column data", 32'(c_data), 32'hC3);
    for (int i = 0; i < 8; i++) begin
      req(0, 0, 1, i, 0, 8'h00);
      flags("R2 stream", 1, 0, 0);
      check("R2 stream data", 32'(c_data), 32'h30 + 32'(i));
    end
    check("R8 active bank awake", 32'(bank_standby[0]), 32'd0);
    check("R8 idle bank standby", 32'(bank_standby[3]), 32'd1);
    @(negedge clk);
    check("R8 back to standby", 32'(bank_standby[0]), 32'd1);
    req(0, 0, 1, 6, 1, 8'h66);
    req(0, 0, 1, 6, 0, 8'h00);
    check("R3 write seen next cycle", 32'(c_data), 32'h66);
  endtask

  task automatic t_concurrent();
    req(0, 2, 3, 0, 0, 8'h00);
    flags("R4 miss bank2", 0, 1, 0);
    req(0, 0, 1, 2, 0, 8'h00);
    flags("R7 hit during load", 1, 0, 0);
    check("R7 hit data during load", 32'(c_data), 32'h32);
    check("R7 bank2 busy", 32'(bank_busy[2]), 32'd1);
    wait_ready();
  endtask

  task automatic t_writeback();
    open_row(0, 2);
    req(0, 0, 2, 3, 1, 8'h11);
    req(0, 0, 1, 3, 1, 8'h5A);
    flags("R4 write miss dropped", 0, 1, 0);
    wait_ready();
    req(0, 0, 1, 3, 0, 8'h00);
    flags("R9 reopen row1", 1, 0, 0);
    check("R9 R4 row1 byte kept", 32'(c_data), 32'h33);
    open_row(0, 2);
    req(0, 0, 2, 3, 0, 8'h00);
    check("R9 row2 byte kept", 32'(c_data), 32'h11);
  endtask

  task automatic t_mode();
    req(1, 0, 0, 0, 0, 8'h01);
    flags("R10 cfg no response", 0, 0, 0);
    req(0, 0, 2, 3, 0, 8'h00);
    flags("R10 reads blocked", 0, 0, 0);
    req(1, 0, 0, 0, 0, 8'h02);
    req(0, 0, 2, 3, 1, 8'hEE);
    req(0, 0, 2, 3, 0, 8'h00);
    flags("R10 reads allowed", 1, 0, 0);
    check("R10 write blocked", 32'(c_data), 32'h11);
    req(1, 0, 0, 0, 0, 8'h00);
    req(0, 0, 2, 3, 1, 8'hEE);
    req(0, 0, 2, 3, 0, 8'h00);
    check("R10 write allowed", 32'(c_data), 32'hEE);
    check("R10 cfg left banks idle", 32'(bank_busy), 32'h0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_cfg = 1'b0; req_we = 1'b0;
    req_bank = '0; req_row = '0; req_col = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_miss_busy();
    t_stream();
    t_concurrent();
    t_writeback();
    t_mode();
    finish_run();
  end

endmodule